// File: doc/BRIEF.md
# Job Ring Controller

This block runs one pair of job rings: an inbound ring that software fills with job descriptors, and an outbound ring where completed jobs are returned. Software and hardware never exchange head or tail pointers. They exchange counts instead. Software reads how many inbound slots are free, fills some of them and writes that number to an add register. Later it reads how many completions are waiting and writes back how many it has consumed.

Once enabled, the controller takes jobs in strict submission order, one at a time. For each job it presents the descriptor address to an execution engine and waits for a done pulse. It then writes that same descriptor address into the next outbound slot, so software can match each completion to its submission. Every completion posted raises the interrupt. Count mistakes by software and job failures reported by the engine raise an error flag. A single write to the interrupt status register clears the interrupt state.

Top module: `job_ring_ctrl`

## Requirements
- R1: After reset, AVAIL (word 0x8) reads SIZE, FULL (word 0xA) reads 0, irq_o is low, and the ring size register (word 0x3) reads SIZE.
- R2: Writing N to ADD (word 0x9), with N no larger than AVAIL, makes N jobs pending and lowers AVAIL by N. An inbound slot is returned to AVAIL when its completion is posted.
- R3: No job starts while the enable bit (bit 0 of word 0x0) is 0. Jobs that are pending start once the bit is written to 1.
- R4: Jobs start one at a time and in submission order. The address of job k is inbound base + 16 × (k mod SIZE), where the base is word 0x5 (high) : word 0x4 (low).
- R5: Completion k writes the address of job k to outbound base + 16 × (k mod SIZE), where the base is word 0x7 (high) : word 0x6 (low). Each posted entry adds one to FULL.
- R6: Writing N to REMOVED (word 0xB), with N no larger than FULL, lowers FULL by N.
- R7: Each posted completion sets bit 0 of IRQ_STAT (word 0x1) and drives irq_o high. Any write to IRQ_STAT clears both IRQ_STAT and STATUS (word 0x2).
- R8: While FULL equals SIZE, a finished job is held back and not posted, and no further job starts. Both resume once software removes entries.
- R9: An ADD count larger than AVAIL, or a REMOVED count larger than FULL, changes no count. It sets STATUS bit 0 or bit 1 respectively, and sets IRQ_STAT bit 1.
- R10: A done pulse that comes with job_err_i sets STATUS bit 2 and IRQ_STAT bit 1. The job is still posted to the outbound ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| job_start_o | output | 1 | One-cycle pulse that starts a job |
| job_addr_o | output | AW | Descriptor address of the current job |
| job_done_i | input | 1 | Execution engine reports that the job has finished |
| job_err_i | input | 1 | Job failed; qualified by job_done_i |
| out_wr_o | output | 1 | Outbound slot write strobe |
| out_wr_addr_o | output | AW | Address of the outbound slot being written |
| out_wr_data_o | output | AW | Completed descriptor address |
| irq_o | output | 1 | Interrupt, high while any IRQ_STAT bit is set |

## Verification
The bench builds the controller with RING_LOG2 = 2, which gives four-entry rings and 16-byte slots. With rings this small, a short directed sequence can run the index past the last slot and back to zero. It can also fill the outbound ring completely, so a finished job stalls with a second job still queued behind it. Both over-count cases sit at single-digit values, which makes the exact counts easy to check.

// File: rtl/job_ring_pkg.sv
`timescale 1ns/1ps
package job_ring_pkg;
  typedef enum logic [3:0] {
    REG_CMD    = 4'h0,
    REG_IRQ    = 4'h1,
    REG_STAT   = 4'h2,
    REG_SIZE   = 4'h3,
    REG_IN_LO  = 4'h4,
    REG_IN_HI  = 4'h5,
    REG_OUT_LO = 4'h6,
    REG_OUT_HI = 4'h7,
    REG_AVAIL  = 4'h8,
    REG_ADD    = 4'h9,
    REG_FULL   = 4'hA,
    REG_RMVD   = 4'hB
  } reg_addr_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_WAIT, SQ_POST} seq_state_e;

  localparam int unsigned STAT_ADD_OVF = 0;
  localparam int unsigned STAT_RMV_UNF = 1;
  localparam int unsigned STAT_JOB_ERR = 2;
  localparam int unsigned IRQ_DONE     = 0;
  localparam int unsigned IRQ_ERR      = 1;
endpackage

// File: rtl/job_ring_occ.sv
`timescale 1ns/1ps
// Occupancy counter: adds inc_i and subtracts dec_i each cycle.
module job_ring_occ #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] inc_i,
  input  logic [CW-1:0] dec_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + inc_i - dec_i;
  end
endmodule

// File: rtl/job_ring_idx.sv
`timescale 1ns/1ps
// Ring index: advances by one per entry and wraps at the power-of-two size.
module job_ring_idx #(
  parameter int unsigned IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (adv_i) idx_o <= idx_o + 1'b1;
  end
endmodule

// File: rtl/job_ring_seq.sv
`timescale 1ns/1ps
module job_ring_seq import job_ring_pkg::*; #(
  parameter int unsigned AW         = 64,
  parameter int unsigned RING_LOG2  = 4,
  parameter int unsigned ENTRY_LOG2 = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          job_pend_i,
  input  logic          out_full_i,
  input  logic [AW-1:0] in_base_i,
  input  logic [AW-1:0] out_base_i,
  output logic          job_start_o,
  output logic [AW-1:0] job_addr_o,
  input  logic          job_done_i,
  input  logic          job_err_i,
  output logic          job_err_o,
  output logic          out_wr_o,
  output logic [AW-1:0] out_wr_addr_o,
  output logic [AW-1:0] out_wr_data_o
);
  localparam int unsigned PADW = AW - RING_LOG2 - ENTRY_LOG2;

  seq_state_e           state_q, state_d;
  logic [AW-1:0]        job_addr_q;
  logic [RING_LOG2-1:0] in_idx, out_idx;
  logic                 launch, post;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [RING_LOG2-1:0] idx);
    return base + {{PADW{1'b0}}, idx, {ENTRY_LOG2{1'b0}}};
  endfunction

  assign launch = (state_q == SQ_IDLE) && enable_i && job_pend_i;
  assign post   = (state_q == SQ_POST) && !out_full_i;

  job_ring_idx #(.IW(RING_LOG2)) u_in_idx (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(state_q == SQ_START), .idx_o(in_idx)
  );
  job_ring_idx #(.IW(RING_LOG2)) u_out_idx (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(post), .idx_o(out_idx)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (launch) state_d = SQ_START;
      SQ_START: state_d = SQ_WAIT;
      SQ_WAIT:  if (job_done_i) state_d = SQ_POST;
      SQ_POST:  if (!out_full_i) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      job_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (launch) job_addr_q <= slot_addr(in_base_i, in_idx);
    end
  end

  assign job_start_o   = (state_q == SQ_START);
  assign job_addr_o    = job_addr_q;
  assign job_err_o     = (state_q == SQ_WAIT) && job_done_i && job_err_i;
  assign out_wr_o      = post;
  assign out_wr_addr_o = slot_addr(out_base_i, out_idx);
  assign out_wr_data_o = job_addr_q;
endmodule

// File: rtl/job_ring_ctrl.sv
`timescale 1ns/1ps
module job_ring_ctrl import job_ring_pkg::*; #(
  parameter int unsigned AW         = 64,
  parameter int unsigned RING_LOG2  = 4,
  parameter int unsigned ENTRY_LOG2 = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          job_start_o,
  output logic [AW-1:0] job_addr_o,
  input  logic          job_done_i,
  input  logic          job_err_i,
  output logic          out_wr_o,
  output logic [AW-1:0] out_wr_addr_o,
  output logic [AW-1:0] out_wr_data_o,
  output logic          irq_o
);
  localparam int unsigned CW     = RING_LOG2 + 1;
  localparam logic [CW-1:0] SIZE_C = CW'(1 << RING_LOG2);

  logic          enable_q;
  logic [AW-1:0] in_base_q, out_base_q;
  logic [1:0]    irq_q;
  logic [2:0]    stat_q;
  logic [CW-1:0] in_cnt, out_cnt, avail;
  logic          add_wr, add_ok, add_bad, rmv_wr, rmv_ok, rmv_bad;
  logic          irq_clr, job_err_evt, err_evt;

  assign avail   = SIZE_C - in_cnt;
  assign add_wr  = reg_we_i && (reg_addr_i == REG_ADD);
  assign add_ok  = add_wr && (reg_wdata_i <= 32'(avail));
  assign add_bad = add_wr && !add_ok;
  assign rmv_wr  = reg_we_i && (reg_addr_i == REG_RMVD);
  assign rmv_ok  = rmv_wr && (reg_wdata_i <= 32'(out_cnt));
  assign rmv_bad = rmv_wr && !rmv_ok;
  assign irq_clr = reg_we_i && (reg_addr_i == REG_IRQ);
  assign err_evt = add_bad || rmv_bad || job_err_evt;

  job_ring_occ #(.CW(CW)) u_in_occ (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(add_ok ? CW'(reg_wdata_i) : '0),
    .dec_i(CW'(out_wr_o)),
    .cnt_o(in_cnt)
  );
  job_ring_occ #(.CW(CW)) u_out_occ (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(CW'(out_wr_o)),
    .dec_i(rmv_ok ? CW'(reg_wdata_i) : '0),
    .cnt_o(out_cnt)
  );

  job_ring_seq #(.AW(AW), .RING_LOG2(RING_LOG2), .ENTRY_LOG2(ENTRY_LOG2)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .enable_i(enable_q),
    .job_pend_i(in_cnt != '0),
    .out_full_i(out_cnt == SIZE_C),
    .in_base_i(in_base_q), .out_base_i(out_base_q),
    .job_start_o(job_start_o), .job_addr_o(job_addr_o),
    .job_done_i(job_done_i), .job_err_i(job_err_i), .job_err_o(job_err_evt),
    .out_wr_o(out_wr_o), .out_wr_addr_o(out_wr_addr_o), .out_wr_data_o(out_wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q   <= 1'b0;
      in_base_q  <= '0;
      out_base_q <= '0;
      irq_q      <= '0;
      stat_q     <= '0;
    end else begin
      if (reg_we_i) begin
        unique case (reg_addr_i)
          REG_CMD:    enable_q <= reg_wdata_i[0];
          REG_IN_LO:  in_base_q[31:0]     <= reg_wdata_i;
          REG_IN_HI:  in_base_q[AW-1:32]  <= reg_wdata_i[AW-33:0];
          REG_OUT_LO: out_base_q[31:0]    <= reg_wdata_i;
          REG_OUT_HI: out_base_q[AW-1:32] <= reg_wdata_i[AW-33:0];
          default: ;
        endcase
      end
      // New events win over a clear in the same cycle.
      irq_q[IRQ_DONE]      <= (irq_q[IRQ_DONE] && !irq_clr) || out_wr_o;
      irq_q[IRQ_ERR]       <= (irq_q[IRQ_ERR] && !irq_clr) || err_evt;
      stat_q[STAT_ADD_OVF] <= (stat_q[STAT_ADD_OVF] && !irq_clr) || add_bad;
      stat_q[STAT_RMV_UNF] <= (stat_q[STAT_RMV_UNF] && !irq_clr) || rmv_bad;
      stat_q[STAT_JOB_ERR] <= (stat_q[STAT_JOB_ERR] && !irq_clr) || job_err_evt;
    end
  end

  assign irq_o = |irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CMD:    reg_rdata_o = {31'b0, enable_q};
      REG_IRQ:    reg_rdata_o = {30'b0, irq_q};
      REG_STAT:   reg_rdata_o = {29'b0, stat_q};
      REG_SIZE:   reg_rdata_o = 32'(SIZE_C);
      REG_IN_LO:  reg_rdata_o = in_base_q[31:0];
      REG_IN_HI:  reg_rdata_o = 32'(in_base_q[AW-1:32]);
      REG_OUT_LO: reg_rdata_o = out_base_q[31:0];
      REG_OUT_HI: reg_rdata_o = 32'(out_base_q[AW-1:32]);
      REG_AVAIL:  reg_rdata_o = 32'(avail);
      REG_FULL:   reg_rdata_o = 32'(out_cnt);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/job_ring_chk.sv
`timescale 1ns/1ps
module job_ring_chk #(
  parameter int unsigned CW   = 5,
  parameter int unsigned SIZE = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          job_start_i,
  input logic          out_wr_i,
  input logic          irq_i,
  input logic          rmv_ok_i,
  input logic [CW-1:0] in_cnt_i,
  input logic [CW-1:0] out_cnt_i
);
  p_in_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cnt_i <= CW'(SIZE));

  p_start_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_start_i |-> $past(enable_i));

  p_single_job_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_start_i |=> !job_start_i);

  p_full_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_wr_i && !rmv_ok_i) |=> out_cnt_i == CW'($past(out_cnt_i) + 1'b1));

  p_irq_on_post_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr_i |=> irq_i);

  p_no_post_when_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr_i |-> out_cnt_i < CW'(SIZE));
endmodule

bind job_ring_ctrl job_ring_chk #(.CW(CW), .SIZE(1 << RING_LOG2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_q),
  .job_start_i(job_start_o), .out_wr_i(out_wr_o), .irq_i(irq_o),
  .rmv_ok_i(rmv_ok), .in_cnt_i(in_cnt), .out_cnt_i(out_cnt)
);

// File: tb/job_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module job_ring_ctrl_tb_top;
  localparam int unsigned AW = 64;
  localparam int unsigned RL = 2;
  localparam int unsigned SZ = 1 << RL;
  localparam logic [63:0] IN_BASE  = 64'h0000_0010_0000_1000;
  localparam logic [63:0] OUT_BASE = 64'h0000_0020_0000_2000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [3:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          job_start_o, job_done_i, job_err_i, out_wr_o, irq_o;
  logic [AW-1:0] job_addr_o, out_wr_addr_o, out_wr_data_o;

  int n_chk = 0, n_fail = 0, starts = 0, posts = 0;
  logic err_next = 1'b0;
  logic done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  job_ring_ctrl #(.AW(AW), .RING_LOG2(RL), .ENTRY_LOG2(4)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .job_start_o(job_start_o), .job_addr_o(job_addr_o),
    .job_done_i(job_done_i), .job_err_i(job_err_i),
    .out_wr_o(out_wr_o), .out_wr_addr_o(out_wr_addr_o), .out_wr_data_o(out_wr_data_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input string req, input string what,
                        input logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #0.5;
    chk(req, what, {32'b0, reg_rdata_o}, {32'b0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // Execution engine model: done three cycles after each start.
  initial begin
    job_done_i = 1'b0; job_err_i = 1'b0;
    forever begin
      @(negedge clk_i);
      if (job_start_o) begin
        chk("R4", "job address", job_addr_o, IN_BASE + 64'((starts % SZ) * 16));
        starts++;
        repeat (3) @(negedge clk_i);
        job_done_i = 1'b1; job_err_i = err_next;
        @(negedge clk_i);
        job_done_i = 1'b0; job_err_i = 1'b0; err_next = 1'b0;
      end
    end
  end

  // Outbound monitor: completion k must carry job k's address into slot k mod SIZE.
  initial begin
    forever begin
      @(negedge clk_i);
      if (out_wr_o) begin
        chk("R5", "outbound slot", out_wr_addr_o, OUT_BASE + 64'((posts % SZ) * 16));
        chk("R5", "outbound data", out_wr_data_o, IN_BASE + 64'((posts % SZ) * 16));
        posts++;
      end
    end
  end

  task automatic t_reset;
    rd_chk(4'h8, "R1", "avail after reset", SZ);
    rd_chk(4'hA, "R1", "full after reset", 0);
    rd_chk(4'h3, "R1", "ring size", SZ);
    chk("R1", "irq after reset", {63'b0, irq_o}, 64'd0);
  endtask

  task automatic t_enable_gate;
    wr(4'h4, IN_BASE[31:0]);  wr(4'h5, IN_BASE[63:32]);
    wr(4'h6, OUT_BASE[31:0]); wr(4'h7, OUT_BASE[63:32]);
    wr(4'h9, 2);
    idle(20);
    chk("R3", "no start while disabled", 64'(starts), 64'd0);
    rd_chk(4'h8, "R2", "avail after add 2", SZ - 2);
    wr(4'h0, 1);
    idle(30);
    rd_chk(4'hA, "R5", "full after 2 jobs", 2);
    rd_chk(4'h8, "R2", "avail restored after posting", SZ);
    chk("R7", "irq after completion", {63'b0, irq_o}, 64'd1);
    chk("R4", "posts in order", 64'(posts), 64'd2);
  endtask

  task automatic t_irq_clear;
    rd_chk(4'h1, "R7", "irq status done bit", 1);
    wr(4'h1, 0);
    chk("R7", "irq_o after clear", {63'b0, irq_o}, 64'd0);
    rd_chk(4'h1, "R7", "irq status after clear", 0);
  endtask

  task automatic t_remove;
    wr(4'hB, 2);
    rd_chk(4'hA, "R6", "full after remove 2", 0);
  endtask

  task automatic t_wrap;
    wr(4'h9, 3);
    idle(40);
    chk("R4", "posts across wrap", 64'(posts), 64'd5);
    rd_chk(4'hA, "R5", "full after 3 more", 3);
    wr(4'hB, 3);
    rd_chk(4'hA, "R6", "full after remove 3", 0);
  endtask

  task automatic t_stall;
    wr(4'h9, 4);
    idle(50);
    rd_chk(4'hA, "R8", "outbound filled", SZ);
    wr(4'h9, 2);
    idle(30);
    chk("R8", "no post while full", 64'(posts), 64'd9);
    chk("R8", "no second start while held", 64'(starts), 64'd10);
    rd_chk(4'hA, "R8", "full held", SZ);
    rd_chk(4'h8, "R8", "avail with two held", SZ - 2);
    wr(4'hB, 1);
    idle(30);
    chk("R8", "resume after one removal", 64'(posts), 64'd10);
    chk("R8", "next start after resume", 64'(starts), 64'd11);
    wr(4'hB, 4);
    idle(20);
    chk("R8", "last held job posted", 64'(posts), 64'd11);
    rd_chk(4'hA, "R6", "full after drain", 1);
    wr(4'hB, 1);
    wr(4'h1, 0);
  endtask

  task automatic t_disable;
    wr(4'h0, 0);
    wr(4'h9, 1);
    idle(20);
    chk("R3", "no start after disable", 64'(starts), 64'd11);
    wr(4'h0, 1);
    idle(20);
    chk("R3", "start after re-enable", 64'(posts), 64'd12);
    wr(4'hB, 1);
    wr(4'h1, 0);
  endtask

  task automatic t_overcount;
    wr(4'h9, SZ + 1);
    idle(10);
    rd_chk(4'h8, "R9", "avail unchanged by bad add", SZ);
    chk("R9", "no start from bad add", 64'(starts), 64'd12);
    rd_chk(4'h2, "R9", "status add overflow", 1);
    rd_chk(4'h1, "R9", "irq error bit", 2);
    chk("R9", "irq_o on error", {63'b0, irq_o}, 64'd1);
    wr(4'hB, 1);
    rd_chk(4'hA, "R9", "full unchanged by bad remove", 0);
    rd_chk(4'h2, "R9", "status remove underflow", 3);
    wr(4'h1, 0);
    rd_chk(4'h2, "R7", "status cleared by irq write", 0);
  endtask

  task automatic t_job_err;
    err_next = 1'b1;
    wr(4'h9, 1);
    idle(20);
    rd_chk(4'h2, "R10", "status job error", 4);
    rd_chk(4'h1, "R10", "irq done and error", 3);
    rd_chk(4'hA, "R10", "failed job still posted", 1);
    wr(4'hB, 1);
    wr(4'h1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_enable_gate();
    t_irq_clear();
    t_remove();
    t_wrap();
    t_stall();
    t_disable();
    t_overcount();
    t_job_err();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end
endmodule